// File: doc/BRIEF.md
# Five-Bank Symbol Buffer Rotation Controller

This controller decides, for every OFDM symbol period of a 2×1 space-time block coded receiver, which of five symbol-sized memory banks each of three agents may use. The agents are the sample writer fed by timing recovery, the in-place FFT engine, and the channel-estimation reader. The reader consumes both symbols of a coded slot together. Capture, transform and consumption therefore overlap across symbols, and no bank is ever claimed twice in one period.

The banks form two families. Family 0 holds two banks, with codes 0 and 1. Family 1 holds three banks, with codes 2, 3 and 4. The first symbol of every slot is written into family 1 and the second into family 0. A bank holding a slot's first symbol stays busy for five periods: written, transformed, held for one period, then read for two. A bank holding a slot's second symbol stays busy for four periods. Cycling family 1 in steps of three and family 0 in steps of two gives a pattern that repeats every 12 symbols.

A symbol-start strobe advances the schedule. When a frame-start flag comes with that strobe, the schedule restarts at phase 0. Each agent gets a registered enable and bank code. The reader gets two codes: the lead bank (the slot's first symbol) and the lag bank (the slot's second symbol). It also gets a flag that tells which of its two read periods is current.

Top module: `symbank_rotator`

## Requirements
- R1: While reset is high and after it is released, all enables are low, all bank codes are 0, `ce_second` is 0 and `clash_err` is 0.
- R2: The outputs change only at a clock edge where `sym_start` is high. Between strobes they hold their values.
- R3: Before the first frame start after reset, `sym_start` strobes leave every enable low.
- R4: The writer is enabled in every symbol of a running frame. At frame phase p (0..11), an even p gives `wr_bank` = 2 + (p/2 mod 3) and an odd p gives `wr_bank` = (p/2 mod 2), using integer division.
- R5: From the second symbol of a frame onward, `fft_en` is high and `fft_bank` equals the writer bank of the previous symbol. In the first symbol `fft_en` is low.
- R6: From the fourth symbol of a frame onward, `ce_en` is high. At an odd phase, `ce_lead_bank` and `ce_lag_bank` are the writer banks from 3 and 2 symbols back, and `ce_second` = 0. At an even phase, they are the writer banks from 4 and 3 symbols back, and `ce_second` = 1.
- R7: The phase counts 0..11 and wraps from 11 to 0, so the bank pattern repeats every 12 symbols.
- R8: A strobe that comes with `frame_start` restarts the schedule at phase 0 in any phase. `wr_bank` becomes 2, and the FFT and reader enables drop until their warm-up has passed again.
- R9: No two enabled agent bank fields (writer, FFT, lead, lag) are equal in any symbol. `clash_err` flags any such equality and stays 0.
- R10: An agent whose enable is low shows bank code 0. When `ce_en` is low, `ce_second` is 0.
- R11: `frame_start` without `sym_start` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_start | input | 1 | One-cycle strobe that starts a symbol period |
| frame_start | input | 1 | Restarts the schedule when it comes with `sym_start` |
| wr_en | output | 1 | Writer active this symbol |
| wr_bank | output | 3 | Bank code the writer fills |
| fft_en | output | 1 | FFT engine active this symbol |
| fft_bank | output | 3 | Bank code transformed in place |
| ce_en | output | 1 | Channel-estimation reader active |
| ce_lead_bank | output | 3 | Bank with the slot's first symbol |
| ce_lag_bank | output | 3 | Bank with the slot's second symbol |
| ce_second | output | 1 | High in the reader's second period on the slot |
| clash_err | output | 1 | Two enabled agents share a bank |

## Verification
Every result registers at the same edge that samples the strobe, so each output is due one cycle after `sym_start` is driven. The bench samples it at the falling edge that follows. During the idle cycles between strobes, the bench checks the same expected values again at every falling edge, and this is how R2 and R11 are covered. Expected codes come from the phase formula and from a short history of expected writer banks kept in the bench. The bench restarts the frame at each of the 12 phases and runs long enough to cover the wrap and the warm-up of the FFT engine and the reader.

// File: rtl/symbank_pkg.sv
package symbank_pkg;

    // bank families: family 0 holds second symbols, family 1 first symbols
    localparam int FAM0_N   = 2;
    localparam int FAM1_N   = 3;
    localparam int BANKS    = FAM0_N + FAM1_N;
    // family sizes are coprime, so the joint cycle is 2*FAM0_N*FAM1_N symbols
    localparam int PERIOD   = 2 * FAM0_N * FAM1_N;
    localparam int BANK_W   = $clog2(BANKS);
    localparam int PH_W     = $clog2(PERIOD);
    // symbols since frame start before each consumer may run
    localparam int FFT_AGE  = 1;
    localparam int CE_AGE   = 3;
    localparam int AGE_W    = $clog2(CE_AGE + 1);
    localparam int N_TAKERS = 4;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [AGE_W-1:0]  age_t;

    typedef enum logic [1:0] {
        TK_WR   = 2'd0,
        TK_FFT  = 2'd1,
        TK_LEAD = 2'd2,
        TK_LAG  = 2'd3
    } taker_e;

    typedef struct packed {
        logic  en;
        bank_t bank;
    } grant_t;

    typedef struct packed {
        grant_t wr;
        grant_t fft;
        logic   ce_en;
        bank_t  ce_lead;
        bank_t  ce_lag;
        logic   ce_second;
    } sched_t;

    function automatic phase_t ph_back(phase_t p, int unsigned d);
        int unsigned t;
        t = (int'(p) + PERIOD - d) % PERIOD;
        return phase_t'(t);
    endfunction

    function automatic bank_t writer_bank(phase_t p);
        int unsigned half;
        half = int'(p) / 2;
        if (p[0] == 1'b0)
            return bank_t'(FAM0_N + (half % FAM1_N));
        else
            return bank_t'(half % FAM0_N);
    endfunction

endpackage

// File: rtl/symbank_phase_ctr.sv
module symbank_phase_ctr
    import symbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sym_start,
    input  logic   frame_start,
    output phase_t phase_n,
    output logic   active_n,
    output age_t   age_n
);
    localparam phase_t PH_LAST = phase_t'(PERIOD - 1);
    localparam age_t   AGE_SAT = age_t'(CE_AGE);

    phase_t phase_q;
    logic   active_q;
    age_t   age_q;

    always_comb begin
        phase_n  = phase_q;
        active_n = active_q;
        age_n    = age_q;
        if (sym_start) begin
            if (frame_start) begin
                phase_n  = '0;
                active_n = 1'b1;
                age_n    = '0;
            end else if (active_q) begin
                phase_n = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                if (age_q != AGE_SAT)
                    age_n = age_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            active_q <= 1'b0;
            age_q    <= '0;
        end else begin
            phase_q  <= phase_n;
            active_q <= active_n;
            age_q    <= age_n;
        end
    end

    p_phase_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(phase_q) < PERIOD);

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (sym_start && !frame_start && active_q && phase_q == PH_LAST) |=> phase_q == '0);

    p_idle_before_frame_r3: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !frame_start) |=> !active_q);

    p_no_strobe_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !sym_start |=> ($stable(phase_q) && $stable(active_q) && $stable(age_q)));

endmodule

// File: rtl/symbank_decode.sv
module symbank_decode
    import symbank_pkg::*;
(
    input  phase_t phase,
    input  logic   active,
    input  age_t   age,
    output sched_t sched
);
    logic odd_ph;
    logic fft_go;
    logic ce_go;

    assign odd_ph = phase[0];
    assign fft_go = active && (int'(age) >= FFT_AGE);
    assign ce_go  = active && (int'(age) >= CE_AGE);

    always_comb begin
        sched = '0;
        if (active) begin
            sched.wr.en   = 1'b1;
            sched.wr.bank = writer_bank(phase);
        end
        if (fft_go) begin
            sched.fft.en   = 1'b1;
            sched.fft.bank = writer_bank(ph_back(phase, 1));
        end
        if (ce_go) begin
            sched.ce_en     = 1'b1;
            sched.ce_second = !odd_ph;
            if (odd_ph) begin
                sched.ce_lead = writer_bank(ph_back(phase, 3));
                sched.ce_lag  = writer_bank(ph_back(phase, 2));
            end else begin
                sched.ce_lead = writer_bank(ph_back(phase, 4));
                sched.ce_lag  = writer_bank(ph_back(phase, 3));
            end
        end
    end

    p_lead_family_r6: assert final (!sched.ce_en || int'(sched.ce_lead) >= FAM0_N);

endmodule

// File: rtl/symbank_clash.sv
module symbank_clash
    import symbank_pkg::*;
(
    input  sched_t sched,
    output logic   clash
);
    logic  [N_TAKERS-1:0]          tk_en;
    bank_t                         tk_bank [N_TAKERS];
    logic  [N_TAKERS*N_TAKERS-1:0] hit;

    always_comb begin
        tk_en[TK_WR]     = sched.wr.en;
        tk_bank[TK_WR]   = sched.wr.bank;
        tk_en[TK_FFT]    = sched.fft.en;
        tk_bank[TK_FFT]  = sched.fft.bank;
        tk_en[TK_LEAD]   = sched.ce_en;
        tk_bank[TK_LEAD] = sched.ce_lead;
        tk_en[TK_LAG]    = sched.ce_en;
        tk_bank[TK_LAG]  = sched.ce_lag;
    end

    for (genvar i = 0; i < N_TAKERS; i++) begin : g_row
        for (genvar j = 0; j < N_TAKERS; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign hit[i*N_TAKERS+j] = tk_en[i] && tk_en[j] && (tk_bank[i] == tk_bank[j]);
            end else begin : g_none
                assign hit[i*N_TAKERS+j] = 1'b0;
            end
        end
    end

    assign clash = |hit;

endmodule

// File: rtl/symbank_rotator.sv
module symbank_rotator
    import symbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_start,
    input  logic              frame_start,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic              fft_en,
    output logic [BANK_W-1:0] fft_bank,
    output logic              ce_en,
    output logic [BANK_W-1:0] ce_lead_bank,
    output logic [BANK_W-1:0] ce_lag_bank,
    output logic              ce_second,
    output logic              clash_err
);
    phase_t phase_n;
    logic   active_n;
    age_t   age_n;
    sched_t sched_d;
    sched_t sched_q;

    symbank_phase_ctr u_phase (
        .clk         (clk),
        .rst         (rst),
        .sym_start   (sym_start),
        .frame_start (frame_start),
        .phase_n     (phase_n),
        .active_n    (active_n),
        .age_n       (age_n)
    );

    symbank_decode u_decode (
        .phase  (phase_n),
        .active (active_n),
        .age    (age_n),
        .sched  (sched_d)
    );

    // selects move only with the symbol strobe
    always_ff @(posedge clk) begin
        if (rst)
            sched_q <= '0;
        else if (sym_start)
            sched_q <= sched_d;
    end

    symbank_clash u_clash (
        .sched (sched_q),
        .clash (clash_err)
    );

    assign wr_en        = sched_q.wr.en;
    assign wr_bank      = sched_q.wr.bank;
    assign fft_en       = sched_q.fft.en;
    assign fft_bank     = sched_q.fft.bank;
    assign ce_en        = sched_q.ce_en;
    assign ce_lead_bank = sched_q.ce_lead;
    assign ce_lag_bank  = sched_q.ce_lag;
    assign ce_second    = sched_q.ce_second;

    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        !sym_start |=> ($stable(wr_en) && $stable(wr_bank) && $stable(fft_en) &&
                        $stable(fft_bank) && $stable(ce_en) && $stable(ce_lead_bank) &&
                        $stable(ce_lag_bank) && $stable(ce_second)));

    p_fft_follows_wr_r5: assert property (@(posedge clk) disable iff (rst)
        (sym_start && !frame_start && wr_en) |=> (fft_en && fft_bank == $past(wr_bank)));

    p_ce_lag_from_fft_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_start && !frame_start) |=>
            (!(ce_en && !ce_second) || ce_lag_bank == $past(fft_bank)));

    p_ce_pair_held_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_start && !frame_start) |=>
            (!(ce_en && ce_second) ||
             (ce_lead_bank == $past(ce_lead_bank) && ce_lag_bank == $past(ce_lag_bank))));

    p_frame_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (sym_start && frame_start) |=>
            (wr_en && wr_bank == bank_t'(FAM0_N) && !fft_en && !ce_en));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || 1'b1) && (wr_en || wr_bank == '0) && (fft_en || fft_bank == '0) &&
        (ce_en || (ce_lead_bank == '0 && ce_lag_bank == '0 && !ce_second)));

    p_no_clash_r9: assert property (@(posedge clk) disable iff (rst) !clash_err);

endmodule

// File: tb/symbank_rotator_bench.sv
module symbank_rotator_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       sym_start;
    logic       frame_start;
    logic       wr_en, fft_en, ce_en, ce_second, clash_err;
    logic [2:0] wr_bank, fft_bank, ce_lead_bank, ce_lag_bank;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    int  m_active = 0;
    int  m_ph     = 0;
    int  m_age    = 0;
    int  hist [5];
    bit  restarted = 0;
    bit  wrapped   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    symbank_rotator u_symbank_rotator (
        .clk          (clk),
        .rst          (rst),
        .sym_start    (sym_start),
        .frame_start  (frame_start),
        .wr_en        (wr_en),
        .wr_bank      (wr_bank),
        .fft_en       (fft_en),
        .fft_bank     (fft_bank),
        .ce_en        (ce_en),
        .ce_lead_bank (ce_lead_bank),
        .ce_lag_bank  (ce_lag_bank),
        .ce_second    (ce_second),
        .clash_err    (clash_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bank_for(int p);
        if (p % 2 == 0) return 2 + ((p / 2) % 3);
        return (p / 2) % 2;
    endfunction

    task automatic check_all(input string ctx);
        int e_wr_en, e_wr, e_fft_en, e_fft, e_ce_en, e_lead, e_lag, e_sec;
        string rw, rf, rc;
        e_wr_en  = m_active;
        e_wr     = m_active ? hist[0] : 0;
        e_fft_en = (m_active != 0 && m_age >= 1) ? 1 : 0;
        e_fft    = e_fft_en ? hist[1] : 0;
        e_ce_en  = (m_active != 0 && m_age >= 3) ? 1 : 0;
        e_lead   = 0; e_lag = 0; e_sec = 0;
        if (e_ce_en != 0) begin
            if (m_ph % 2 == 1) begin e_lead = hist[3]; e_lag = hist[2]; e_sec = 0; end
            else               begin e_lead = hist[4]; e_lag = hist[3]; e_sec = 1; end
        end
        rw = (m_active == 0) ? "R3" : (restarted ? "R8" : (wrapped ? "R7" : "R4"));
        rf = (e_fft_en == 0) ? "R10" : "R5";
        rc = (e_ce_en == 0) ? "R10" : "R6";
        chk(rw,  {ctx, " wr_en"},  int'(wr_en), e_wr_en);
        chk(rw,  {ctx, " wr_bank"}, int'(wr_bank), e_wr);
        chk(restarted ? "R8" : rf, {ctx, " fft_en"}, int'(fft_en), e_fft_en);
        chk(rf,  {ctx, " fft_bank"}, int'(fft_bank), e_fft);
        chk(restarted ? "R8" : rc, {ctx, " ce_en"}, int'(ce_en), e_ce_en);
        chk(rc,  {ctx, " ce_lead"}, int'(ce_lead_bank), e_lead);
        chk(rc,  {ctx, " ce_lag"},  int'(ce_lag_bank), e_lag);
        chk(rc,  {ctx, " ce_second"}, int'(ce_second), e_sec);
        chk("R9", {ctx, " clash"}, int'(clash_err), 0);
    endtask

    // one symbol: strobe, then gap idle cycles checked for stability (R2)
    task automatic do_sym(input bit fs, input int gap);
        @(negedge clk);
        sym_start   = 1'b1;
        frame_start = fs;
        @(negedge clk);
        sym_start   = 1'b0;
        frame_start = 1'b0;
        restarted = 0;
        wrapped   = 0;
        if (fs) begin
            m_active = 1; m_ph = 0; m_age = 0; restarted = 1;
        end else if (m_active != 0) begin
            wrapped = (m_ph == 11);
            m_ph = (m_ph + 1) % 12;
            if (m_age < 3) m_age++;
        end
        if (fs || m_active != 0) begin
            for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = bank_for(m_ph);
        end
        check_all("sym");
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check_all("R2 hold");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) hist[k] = 0;
        rst = 1'b1; sym_start = 1'b0; frame_start = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R11: frame flag without strobe
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
        check_all("R11 lone frame flag");

        // R3: strobes before any frame start
        for (int i = 0; i < 3; i++) do_sym(1'b0, 1);

        // full frames with varying gaps (R4..R7, R9, R10, R2)
        do_sym(1'b1, 2);
        for (int i = 0; i < 29; i++) do_sym(1'b0, i % 3);

        // R11 again mid-frame
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
        check_all("R11 mid-frame flag");

        // R8: restart from every phase
        for (int off = 0; off < 12; off++) begin
            for (int i = 0; i < off; i++) do_sym(1'b0, 0);
            do_sym(1'b1, 1);
            for (int i = 0; i < 5; i++) do_sym(1'b0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule